// File: doc/BRIEF.md
# Stereo Audio Serial Output Formatter

This block takes one left/right pair of 16-bit two's-complement samples in each sample period and sends them out on one serial data line. It also drives the bit clock and the left/right word clock for that line. It acts as the clock master. The bit clock comes from a master clock enable: each enable pulse moves the bit clock by half a period. Output data and the word clock change only on falling bit-clock edges, so a receiver can sample on rising edges.

Two static pins set the frame layout. In the wide layout, a frame has 64 bit clocks and each channel owns a 32-bit field. Inside that field the word can be right-justified, left-justified, delayed by one slot (I2S), or started at a slot marked by an external pulse. In the packed layout, a frame has 32 bit clocks with 16 slots per channel, and only the left-justified and I2S placements exist. Samples enter through a valid/ready handshake into a one-pair holding buffer. The formatter moves the held pair into the output at the next frame boundary.

Top module: `stereo_ser_fmt`

## Requirements
- R1: `bclk_o` is low after reset and changes only in a cycle that has `mclk_en_i` high: each enable gives one half period of the bit clock. `sdata_o` and `lrclk_o` change only at falling bit-clock edges.
- R2: With `packed_i`=0 a frame has 64 slots, with two fields of 32 slots each (left field first). With `packed_i`=1 a frame has 32 slots, with two fields of 16 slots each. Slot numbering restarts at 0 at every frame boundary.
- R3: Each word is sent MSB first, as two's complement. Every slot that carries no word bit is driven to 0.
- R4: Left-justified placement (`place_i`=2'b10): the MSB is in slot 0 of its field and the 16 bits fill slots 0 to 15. `lrclk_o` is high during the left field and low during the right field.
- R5: I2S placement (`place_i`=2'b01): the MSB is in slot 1 of its field, one slot after the word-clock edge. `lrclk_o` is low during the left field and high during the right field. In packed frames the left LSB falls in slot 0 of the right field, and the right LSB falls in slot 0 of the next frame.
- R6: Right-justified placement (`place_i`=2'b00, wide frames only): the LSB is in the last slot of the 32-slot field, slots 0 to 15 of the field are 0, and the word clock follows R4.
- R7: Pulse-positioned placement (`place_i`=2'b11, wide frames only): if `wcc_i` is high at the falling bit-clock edge that starts a slot, the MSB goes in that slot and the following slots carry the remaining bits. The word is cut off at the end of its field. A field with no pulse carries only zeros. The word clock follows R4. In every other placement `wcc_i` has no effect.
- R8: In packed frames the codes 2'b00 and 2'b11 act as left-justified.
- R9: `ready_o` is high while the holding buffer is empty. A pair is taken on a cycle with `valid_i` and `ready_o` both high. `ready_o` then stays low until that pair moves into the output, and a pair offered while `ready_o` is low is ignored.
- R10: The held pair moves into the output at the rising bit-clock edge inside the last slot of a frame, and it is sent from slot 0 of the next frame. A pair that arrives during a frame therefore waits for the next frame. If no pair is held, the previous pair is sent again.
- R11: While reset is asserted, `bclk_o`, `lrclk_o` and `sdata_o` are 0 and `ready_o` is 1. Frames sent before the first pair arrives carry zero words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mclk_en_i | input | 1 | Master clock enable, one bit-clock half period per pulse |
| packed_i | input | 1 | Static: 1 selects 32-slot packed frames |
| place_i | input | 2 | Static placement: 00 right, 01 I2S, 10 left, 11 pulse-positioned |
| wcc_i | input | 1 | MSB position pulse for pulse-positioned placement |
| left_i | input | 16 | Left sample, two's complement |
| right_i | input | 16 | Right sample, two's complement |
| valid_i | input | 1 | Sample pair offered |
| ready_o | output | 1 | Holding buffer empty |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Word (left/right) clock |
| sdata_o | output | 1 | Serial data |

## Verification
The bench acts as a receiver. It decodes slots from the bit clock and computes each expected slot bit from the slot number, the layout pins and the pair that its own model of R10 says is current. The bit for a slot is registered at the falling bit-clock edge that starts the slot and stays stable for the whole slot. The bench therefore compares it on the next rising edge, which comes two system cycles later with the enable pattern used here, and it checks the rise-to-rise spacing of four cycles. Handshake results are due one edge after the offer, so `ready_o` is checked at the falling system-clock edge that follows the accepting rising edge. The frame that uses a pair is the one that begins after the model's load point.

// File: rtl/sof_pkg.sv
package sof_pkg;
  typedef enum logic [1:0] {
    PL_RJ  = 2'b00,
    PL_I2S = 2'b01,
    PL_LJ  = 2'b10,
    PL_PUL = 2'b11
  } place_e;
endpackage

// File: rtl/sof_bclk_gen.sv
module sof_bclk_gen #(
  parameter int SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [SLOT_W-1:0] last_i,
  output logic              bclk_o,
  output logic              fall_o,
  output logic              frame_end_o,
  output logic [SLOT_W-1:0] slot_nxt_o
);
  logic              ph_q;
  logic [SLOT_W-1:0] slot_q;
  logic              at_last;

  assign at_last     = (slot_q >= last_i);
  assign slot_nxt_o  = at_last ? '0 : slot_q + 1'b1;
  assign fall_o      = en_i & ph_q;
  assign frame_end_o = en_i & ~ph_q & at_last;
  assign bclk_o      = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      slot_q <= '1;
    end else if (en_i) begin
      ph_q <= ~ph_q;
      if (ph_q) slot_q <= slot_nxt_o;
    end
  end
endmodule

// File: rtl/sof_smp_buf.sv
module sof_smp_buf #(
  parameter int WORD_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic              ready_o,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              load_i,
  output logic [WORD_W-1:0] cur_l_o,
  output logic [WORD_W-1:0] cur_r_o,
  output logic              prev_lsb_o
);
  logic              pend_q;
  logic [WORD_W-1:0] pend_l_q, pend_r_q;

  assign ready_o = ~pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_l_q   <= '0;
      pend_r_q   <= '0;
      cur_l_o    <= '0;
      cur_r_o    <= '0;
      prev_lsb_o <= 1'b0;
    end else begin
      if (valid_i && !pend_q) begin
        pend_q   <= 1'b1;
        pend_l_q <= left_i;
        pend_r_q <= right_i;
      end
      if (load_i) begin
        // right LSB of the outgoing pair spills into slot 0 in packed I2S
        prev_lsb_o <= cur_r_o[0];
        if (pend_q) begin
          cur_l_o <= pend_l_q;
          cur_r_o <= pend_r_q;
          pend_q  <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sof_slot_mux.sv
module sof_slot_mux
  import sof_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int FIELD_W = 32,
  parameter int SLOT_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              packed_i,
  input  logic [1:0]        place_i,
  input  logic              wcc_i,
  input  logic [WORD_W-1:0] cur_l_i,
  input  logic [WORD_W-1:0] cur_r_i,
  input  logic              prev_lsb_i,
  output logic              bit_o,
  output logic              lr_o
);
  localparam int CW = $clog2(WORD_W) + 1;

  logic [CW-1:0]     cnt_q, cnt_n;
  logic [WORD_W-1:0] w, wd, sh;
  place_e            eff;
  int                half, frame, s, p, sd, pd, ce;
  logic              ch, chd, pul_bit;

  always_comb begin
    half  = packed_i ? WORD_W : FIELD_W;
    frame = 2 * half;
    s     = int'(slot_i);
    ch    = (s >= half);
    p     = ch ? s - half : s;
    w     = ch ? cur_r_i : cur_l_i;
    sd    = (s == 0) ? frame - 1 : s - 1;
    chd   = (sd >= half);
    pd    = chd ? sd - half : sd;
    wd    = chd ? cur_r_i : cur_l_i;
    eff   = place_e'(place_i);
    if (packed_i && eff != PL_I2S) eff = PL_LJ;

    // pulse-positioned counter restarts idle at each field start
    ce      = (p == 0) ? WORD_W : int'(cnt_q);
    pul_bit = 1'b0;
    cnt_n   = CW'(ce);
    sh      = '0;
    if (wcc_i) begin
      pul_bit = w[WORD_W-1];
      cnt_n   = CW'(1);
    end else if (ce < WORD_W) begin
      sh      = w >> (WORD_W - 1 - ce);
      pul_bit = sh[0];
      cnt_n   = CW'(ce + 1);
    end

    bit_o = 1'b0;
    lr_o  = ~ch;
    unique case (eff)
      PL_RJ: begin
        sh = w >> (FIELD_W - 1 - p);
        if (p >= half - WORD_W) bit_o = sh[0];
      end
      PL_I2S: begin
        lr_o = ch;
        sh   = wd >> (WORD_W - 1 - pd);
        if (s == 0 && packed_i) bit_o = prev_lsb_i;
        else if (pd < WORD_W)   bit_o = sh[0];
      end
      PL_LJ: begin
        sh = w >> (WORD_W - 1 - p);
        if (p < WORD_W) bit_o = sh[0];
      end
      PL_PUL: bit_o = pul_bit;
      default: bit_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= CW'(WORD_W);
    else if (fall_i) cnt_q <= cnt_n;
  end
endmodule

// File: rtl/stereo_ser_fmt.sv
module stereo_ser_fmt #(
  parameter int WORD_W  = 16,
  parameter int FIELD_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mclk_en_i,
  input  logic              packed_i,
  input  logic [1:0]        place_i,
  input  logic              wcc_i,
  input  logic [WORD_W-1:0] left_i,
  input  logic [WORD_W-1:0] right_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              bclk_o,
  output logic              lrclk_o,
  output logic              sdata_o
);
  localparam int SLOT_W = $clog2(2 * FIELD_W);

  logic [SLOT_W-1:0] last_slot, slot_nxt;
  logic              fall, frame_end, prev_lsb, bit_n, lr_n;
  logic [WORD_W-1:0] cur_l, cur_r;

  assign last_slot = packed_i ? SLOT_W'(2 * WORD_W - 1) : SLOT_W'(2 * FIELD_W - 1);

  sof_bclk_gen #(.SLOT_W(SLOT_W)) i_bclk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (mclk_en_i),
    .last_i      (last_slot),
    .bclk_o      (bclk_o),
    .fall_o      (fall),
    .frame_end_o (frame_end),
    .slot_nxt_o  (slot_nxt)
  );

  sof_smp_buf #(.WORD_W(WORD_W)) i_buf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .ready_o    (ready_o),
    .left_i     (left_i),
    .right_i    (right_i),
    .load_i     (frame_end),
    .cur_l_o    (cur_l),
    .cur_r_o    (cur_r),
    .prev_lsb_o (prev_lsb)
  );

  sof_slot_mux #(.WORD_W(WORD_W), .FIELD_W(FIELD_W), .SLOT_W(SLOT_W)) i_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fall_i     (fall),
    .slot_i     (slot_nxt),
    .packed_i   (packed_i),
    .place_i    (place_i),
    .wcc_i      (wcc_i),
    .cur_l_i    (cur_l),
    .cur_r_i    (cur_r),
    .prev_lsb_i (prev_lsb),
    .bit_o      (bit_n),
    .lr_o       (lr_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdata_o <= 1'b0;
      lrclk_o <= 1'b0;
    end else if (fall) begin
      sdata_o <= bit_n;
      lrclk_o <= lr_n;
    end
  end
endmodule

// File: rtl/sof_checker.sv
module sof_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic mclk_en_i,
  input logic valid_i,
  input logic ready_o,
  input logic bclk_o,
  input logic lrclk_o,
  input logic sdata_o
);
  a_r1_bclk_on_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(bclk_o) |-> $past(mclk_en_i));

  a_r1_data_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdata_o) |-> $fell(bclk_o));

  a_r1_lr_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrclk_o) |-> $fell(bclk_o));

  a_r9_take_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

  a_r10_free_at_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> $rose(bclk_o));
endmodule

bind stereo_ser_fmt sof_checker i_sof_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mclk_en_i (mclk_en_i),
  .valid_i   (valid_i),
  .ready_o   (ready_o),
  .bclk_o    (bclk_o),
  .lrclk_o   (lrclk_o),
  .sdata_o   (sdata_o)
);

// File: tb/test_stereo_ser_fmt.sv
module test_stereo_ser_fmt;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        pk = 1'b0;
  logic [1:0]  pl = 2'b00;
  logic        wcc = 1'b0;
  logic [15:0] l_in = '0, r_in = '0;
  logic        valid = 1'b0;
  logic        ready, bclk, lrclk, sdata;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // receiver model state
  int          mslot, frames, last_rise, half, frame_n, mcnt, tgt_a, tgt_b, cfg;
  logic        prev_b, started, exp_b, exp_lr, prev_lsb, pend_v, ack_chk;
  logic [15:0] cur_l, cur_r, pend_l, pend_r;

  always #4 clk = ~clk;

  stereo_ser_fmt i_stereo_ser_fmt (
    .clk_i(clk), .rst_ni(rst_n), .mclk_en_i(en), .packed_i(pk), .place_i(pl),
    .wcc_i(wcc), .left_i(l_in), .right_i(r_in), .valid_i(valid),
    .ready_o(ready), .bclk_o(bclk), .lrclk_o(lrclk), .sdata_o(sdata)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cfg %0d slot %0d)", req, act, exp, cfg, mslot);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // expected slot contents from the requirements
  task automatic model_slot(input int s);
    int ch, p, sd, pd, eff, ce;
    logic [15:0] w, wd;
    logic pb;
    ch  = (s >= half) ? 1 : 0;
    p   = s % half;
    w   = ch ? cur_r : cur_l;
    sd  = (s == 0) ? frame_n - 1 : s - 1;
    pd  = sd % half;
    wd  = (sd >= half) ? cur_r : cur_l;
    eff = (pk && pl != 2'b01) ? 2 : int'(pl);  // R8
    ce  = (p == 0) ? 16 : mcnt;
    pb  = 1'b0;
    if (wcc) begin pb = w[15]; mcnt = 1; end
    else if (ce < 16) begin pb = w[15-ce]; mcnt = ce + 1; end
    else mcnt = ce;
    exp_lr = (ch == 0);
    exp_b  = 1'b0;
    case (eff)
      0: if (p >= 16) exp_b = w[31-p];                         // R6
      1: begin                                                 // R5
        exp_lr = (ch == 1);
        if (s == 0 && pk) exp_b = prev_lsb;
        else if (pd < 16) exp_b = wd[15-pd];
      end
      2: if (p < 16) exp_b = w[15-p];                          // R4
      default: exp_b = pb;                                     // R7
    endcase
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      finish_run();
    end
    en = ~en;
    if (valid) begin
      valid = 1'b0;
      if (ack_chk) check(ready == 1'b0, "R9 ready low after take", ready, 0);
      else         check(ready == 1'b0, "R9 ready stays low while held", ready, 0);
    end
    if (bclk && !prev_b) begin
      if (last_rise >= 0) check(cyc - last_rise == 4, "R1 bit clock period", cyc - last_rise, 4);
      last_rise = cyc;
      if (started) begin
        check(sdata == exp_b,  "R3 slot data", sdata, exp_b);
        check(lrclk == exp_lr, "R2 word clock", lrclk, exp_lr);
      end
      if (mslot == frame_n - 1) begin                          // R10
        prev_lsb = cur_r[0];
        if (pend_v) begin cur_l = pend_l; cur_r = pend_r; pend_v = 1'b0; end
      end
      if (mslot == tgt_a - 1 || mslot == tgt_b - 1) wcc = frames[0];
    end
    if (!bclk && prev_b) begin
      mslot   = (mslot + 1) % frame_n;
      started = 1'b1;
      if (mslot == 0) frames++;
      model_slot(mslot);
      wcc = 1'b0;
      if (mslot == 3 && frames <= 4) begin
        check(ready == 1'b1, "R9 ready when empty", ready, 1);
        l_in = 16'(16'h8000 + frames * 16'h2345 + cfg * 16'h0101);
        if (frames == 2) l_in = 16'h7FFF;
        r_in = ~l_in ^ 16'h00F0;
        valid = 1'b1; ack_chk = 1'b1;
        pend_v = 1'b1; pend_l = l_in; pend_r = r_in;
      end else if (mslot == 6 && frames <= 4) begin
        l_in = 16'h1234; r_in = 16'hFEDC;                      // R9 ignored offer
        valid = 1'b1; ack_chk = 1'b0;
      end
    end
    prev_b = bclk;
  endtask

  initial begin
    for (int c = 0; c < 8; c++) begin
      cfg = c;
      rst_n = 1'b0; en = 1'b0; valid = 1'b0; wcc = 1'b0;
      pk = c[2]; pl = 2'(c);
      half = pk ? 16 : 32; frame_n = 2 * half;
      tgt_a = pk ? 4 : 20; tgt_b = half + 5;   // R7 late start truncates at field end
      mslot = frame_n - 1; frames = 0; last_rise = -1; mcnt = 16;
      prev_b = 1'b0; started = 1'b0; prev_lsb = 1'b0; pend_v = 1'b0; ack_chk = 1'b0;
      cur_l = '0; cur_r = '0; pend_l = '0; pend_r = '0;
      repeat (3) @(negedge clk);
      check({bclk, lrclk, sdata, ready} == 4'b0001, "R11 reset state",
            {bclk, lrclk, sdata, ready}, 4'b0001);
      @(negedge clk); rst_n = 1'b1;
      while (frames < 6) step();
    end
    finish_run();
  end
endmodule